// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block resolves the data and control hazards of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the source register numbers of the instructions in decode and in execute with the destination register numbers held in the later stage registers. It also reads the register-write and memory-read control bits that travel with each instruction.

From these comparisons it produces a bypass select for each ALU operand, which picks the register file, the result in the memory stage, or the result in the writeback stage. It detects the one case that bypassing cannot cover: a load in execute whose result the decode instruction needs. In that case it freezes the PC and the fetch/decode register and inserts a bubble into execute. The register file writes before it reads within a cycle, so the writeback stage never needs a path into decode. Branches are not predicted: a branch in decode flushes fetch for a fixed number of cycles, three by default, until its outcome is known.

Top module: `hazard_fwd_unit`

## Requirements
- R1: The select for an ALU operand is 2'b10 when the memory-stage instruction writes a register, its destination is nonzero and equals that operand's execute source. The encoding is 2'b00 for the register file, 2'b10 for the memory stage and 2'b01 for the writeback stage. The value 2'b11 never appears.
- R2: The select is 2'b01 when only the writeback-stage instruction writes a nonzero destination equal to the operand's execute source.
- R3: When the memory stage and the writeback stage both match an operand, the memory stage wins and the select is 2'b10.
- R4: A destination of register zero, or a stage whose register-write bit is clear, never causes forwarding or a stall. The select stays 2'b00.
- R5: A load in execute (memory-read and register-write both set) whose nonzero destination equals either decode source raises `stall_front` and `insert_bubble` in that same cycle.
- R6: An execute instruction that does not read memory, or a load whose destination matches neither decode source, raises no stall. The dependence is covered by the bypass selects.
- R7: A writeback-stage destination that matches a decode source raises no stall and no other output.
- R8: A branch in decode raises `fetch_flush` in that cycle and in the next BRANCH_BUBBLES-1 cycles. `fetch_flush` is low in the cycle after that.
- R9: While a load-use stall holds the branch in decode, `fetch_flush` stays low. The flush run starts in the first cycle without the stall.
- R10: After reset, `fetch_flush` is low until a branch is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_src1 | input | REG_AW | First source register of the decode instruction |
| dec_src2 | input | REG_AW | Second source register of the decode instruction |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| ex_src1 | input | REG_AW | First source register of the execute instruction |
| ex_src2 | input | REG_AW | Second source register of the execute instruction |
| ex_dst | input | REG_AW | Destination register in decode/execute register |
| ex_wr_en | input | 1 | Register-write bit in decode/execute register |
| ex_rd_mem | input | 1 | Memory-read bit in decode/execute register |
| mem_dst | input | REG_AW | Destination register in execute/memory register |
| mem_wr_en | input | 1 | Register-write bit in execute/memory register |
| wb_dst | input | REG_AW | Destination register in memory/writeback register |
| wb_wr_en | input | 1 | Register-write bit in memory/writeback register |
| fwd_sel_a | output | 2 | Bypass select for ALU operand A |
| fwd_sel_b | output | 2 | Bypass select for ALU operand B |
| stall_front | output | 1 | Hold PC and fetch/decode register |
| insert_bubble | output | 1 | Load a bubble with control bits cleared into decode/execute register |
| fetch_flush | output | 1 | Discard the fetched instruction while a branch resolves |

## Verification
The bypass selects are driven with a match in the memory stage only, in the writeback stage only, in both stages, and on each operand alone. Together these show the two sources apart, show that the younger result wins, and show that the operands are independent. The same patterns are then repeated with register zero or a cleared write bit, which shows that the register-write qualification and the zero exemption are present. Stall patterns pair a matching load against a matching ALU instruction, a non-matching load and a writeback match, which isolates the load-use condition from the ordinary dependences. Branch patterns count the flush run cycle by cycle, both with and without a preceding load-use stall, which shows the run length and its ordering against the stall.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  output fwd_sel_e          sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_wr_en && (mem_dst != '0) && (mem_dst == src);
    wb_hit  = wb_wr_en  && (wb_dst  != '0) && (wb_dst  == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // R1: the unused code never appears
  assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11);
  // R4: a source of register zero is never bypassed
  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == FWD_RF));
  // R3: a younger match always selects the memory stage
  assert_mem_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_dst == src && src != '0) |-> (sel == FWD_MEM));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dec_src1,
  input  logic [REG_AW-1:0] dec_src2,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr_en,
  input  logic              ex_rd_mem,
  output logic              load_stall
);
  logic is_load, hit1, hit2;

  always_comb begin
    is_load    = ex_rd_mem && ex_wr_en && (ex_dst != '0);
    hit1       = (ex_dst == dec_src1);
    hit2       = (ex_dst == dec_src2);
    load_stall = is_load && (hit1 || hit2);
  end

  // R6: only a memory read in execute can hold the front end
  assert_stall_only_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |-> ex_rd_mem);
  // R4: a destination of register zero never stalls
  assert_stall_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |-> (ex_dst != '0));
endmodule

// File: rtl/hz_branch_hold.sv
module hz_branch_hold #(
  parameter int BRANCH_BUBBLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_branch,
  input  logic hold,
  output logic flush
);
  localparam int CNT_W = $clog2(BRANCH_BUBBLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BRANCH_BUBBLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, start;

  always_comb begin
    start  = is_branch && !hold && (cnt_q == '0);
    flush  = start || (cnt_q != '0);
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? RELOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Run-length tracker for the R8 check
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (!flush) run_q <= '0;
    else if (run_q != {(CNT_W+1){1'b1}}) run_q <= run_q + 1'b1;
  end

  // R8: a flush run never exceeds the configured bubble count
  assert_flush_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (run_q < (CNT_W+1)'(BRANCH_BUBBLES)));
  // R8: once started, the run continues while the counter is live
  assert_flush_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && run_q < (CNT_W+1)'(BRANCH_BUBBLES - 1)) |=> flush);
  // R9: no new run begins while the front end is held
  assert_no_flush_in_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && cnt_q == '0) |-> !flush);
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW         = 5,
  parameter int BRANCH_BUBBLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dec_src1,
  input  logic [REG_AW-1:0] dec_src2,
  input  logic              dec_is_branch,
  input  logic [REG_AW-1:0] ex_src1,
  input  logic [REG_AW-1:0] ex_src2,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr_en,
  input  logic              ex_rd_mem,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              stall_front,
  output logic              insert_bubble,
  output logic              fetch_flush
);
  localparam int NUM_OPS = 2;

  logic                    rst_n_i;
  logic [REG_AW-1:0]       op_src [NUM_OPS];
  fwd_sel_e                op_sel [NUM_OPS];
  logic                    load_stall;

  hz_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign op_src[0] = ex_src1;
  assign op_src[1] = ex_src2;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_select #(.REG_AW(REG_AW)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .src      (op_src[g]),
      .mem_dst  (mem_dst),
      .mem_wr_en(mem_wr_en),
      .wb_dst   (wb_dst),
      .wb_wr_en (wb_wr_en),
      .sel      (op_sel[g])
    );
  end

  hz_load_use #(.REG_AW(REG_AW)) u_lu (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .dec_src1  (dec_src1),
    .dec_src2  (dec_src2),
    .ex_dst    (ex_dst),
    .ex_wr_en  (ex_wr_en),
    .ex_rd_mem (ex_rd_mem),
    .load_stall(load_stall)
  );

  hz_branch_hold #(.BRANCH_BUBBLES(BRANCH_BUBBLES)) u_br (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .is_branch(dec_is_branch),
    .hold     (load_stall),
    .flush    (fetch_flush)
  );

  assign fwd_sel_a     = op_sel[0];
  assign fwd_sel_b     = op_sel[1];
  assign stall_front   = load_stall;
  assign insert_bubble = load_stall;

  // R5: a matching load always holds the front end and injects a bubble
  assert_load_use_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ex_rd_mem && ex_wr_en && ex_dst != '0 && ex_dst == dec_src1)
      |-> (stall_front && insert_bubble));
  // R7: writeback alone never stalls decode
  assert_wb_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ex_rd_mem) |-> !stall_front);
endmodule

// File: tb/hazard_fwd_unit_bench.sv
`timescale 1ns/1ps
module hazard_fwd_unit_bench;
  localparam int AW = 5;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] dec_src1, dec_src2, ex_src1, ex_src2, ex_dst, mem_dst, wb_dst;
  logic          dec_is_branch, ex_wr_en, ex_rd_mem, mem_wr_en, wb_wr_en;
  logic [1:0]    fwd_sel_a, fwd_sel_b;
  logic          stall_front, insert_bubble, fetch_flush;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hazard_fwd_unit #(.REG_AW(AW), .BRANCH_BUBBLES(NB)) u_hazard_fwd_unit (
    .clk(clk), .rst_n(rst_n),
    .dec_src1(dec_src1), .dec_src2(dec_src2), .dec_is_branch(dec_is_branch),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst(ex_dst),
    .ex_wr_en(ex_wr_en), .ex_rd_mem(ex_rd_mem),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .stall_front(stall_front), .insert_bubble(insert_bubble),
    .fetch_flush(fetch_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_src1 = '0; dec_src2 = '0; dec_is_branch = 1'b0;
    ex_src1 = '0; ex_src2 = '0; ex_dst = '0; ex_wr_en = 1'b0; ex_rd_mem = 1'b0;
    mem_dst = '0; mem_wr_en = 1'b0; wb_dst = '0; wb_wr_en = 1'b0;
  endtask

  // Drive after a falling edge, settle, then sample
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) step();
    #1;
    chk("R10 flush in reset", fetch_flush, 0);
    rst_n = 1'b1;
    repeat (4) step();
    #1;
    chk("R10 flush after reset", fetch_flush, 0);
    chk("R4 idle sel a", fwd_sel_a, 0);
    chk("R4 idle stall", stall_front, 0);
  endtask

  task automatic t_fwd_mem();
    step(); idle();
    ex_src1 = 5'd3; ex_src2 = 5'd4; mem_dst = 5'd3; mem_wr_en = 1'b1;
    #1;
    chk("R1 mem fwd a", fwd_sel_a, 2);
    chk("R1 other operand b", fwd_sel_b, 0);
    chk("R6 alu dep no stall", stall_front, 0);
    ex_src1 = 5'd9; ex_src2 = 5'd3;
    #1;
    chk("R1 mem fwd b", fwd_sel_b, 2);
    chk("R1 a released", fwd_sel_a, 0);
  endtask

  task automatic t_fwd_wb();
    step(); idle();
    ex_src1 = 5'd7; ex_src2 = 5'd7; wb_dst = 5'd7; wb_wr_en = 1'b1;
    mem_dst = 5'd8; mem_wr_en = 1'b1;
    #1;
    chk("R2 wb fwd a", fwd_sel_a, 1);
    chk("R2 wb fwd b", fwd_sel_b, 1);
  endtask

  task automatic t_priority();
    step(); idle();
    ex_src1 = 5'd12; ex_src2 = 5'd13;
    mem_dst = 5'd12; mem_wr_en = 1'b1; wb_dst = 5'd12; wb_wr_en = 1'b1;
    #1;
    chk("R3 younger wins a", fwd_sel_a, 2);
    chk("R3 b untouched", fwd_sel_b, 0);
  endtask

  task automatic t_zero_nowrite();
    step(); idle();
    ex_src1 = 5'd0; ex_src2 = 5'd0;
    mem_dst = 5'd0; mem_wr_en = 1'b1; wb_dst = 5'd0; wb_wr_en = 1'b1;
    #1;
    chk("R4 zero dst a", fwd_sel_a, 0);
    chk("R4 zero dst b", fwd_sel_b, 0);
    ex_src1 = 5'd5; mem_dst = 5'd5; mem_wr_en = 1'b0;
    wb_dst = 5'd5; wb_wr_en = 1'b0;
    #1;
    chk("R4 no write bit", fwd_sel_a, 0);
    ex_dst = 5'd0; ex_wr_en = 1'b1; ex_rd_mem = 1'b1; dec_src1 = 5'd0;
    #1;
    chk("R4 zero load no stall", stall_front, 0);
  endtask

  task automatic t_load_use();
    step(); idle();
    ex_dst = 5'd6; ex_wr_en = 1'b1; ex_rd_mem = 1'b1; dec_src1 = 5'd6;
    #1;
    chk("R5 stall src1", stall_front, 1);
    chk("R5 bubble src1", insert_bubble, 1);
    dec_src1 = 5'd2; dec_src2 = 5'd6;
    #1;
    chk("R5 stall src2", stall_front, 1);
    dec_src2 = 5'd11;
    #1;
    chk("R6 load mismatch", stall_front, 0);
    dec_src2 = 5'd6; ex_rd_mem = 1'b0;
    #1;
    chk("R6 alu match", stall_front, 0);
    chk("R6 alu match bubble", insert_bubble, 0);
  endtask

  task automatic t_wb_decode();
    step(); idle();
    wb_dst = 5'd10; wb_wr_en = 1'b1; dec_src1 = 5'd10; dec_src2 = 5'd10;
    mem_dst = 5'd10; mem_wr_en = 1'b1;
    #1;
    chk("R7 no stall", stall_front, 0);
    chk("R7 no bubble", insert_bubble, 0);
    chk("R7 no flush", fetch_flush, 0);
  endtask

  task automatic t_branch();
    step(); idle();
    dec_is_branch = 1'b1;
    #1;
    chk("R8 flush cycle 0", fetch_flush, 1);
    for (int i = 1; i < NB; i++) begin
      step(); dec_is_branch = 1'b0;
      #1;
      chk("R8 flush run", fetch_flush, 1);
    end
    step();
    #1;
    chk("R8 flush ends", fetch_flush, 0);
  endtask

  task automatic t_branch_stall();
    step(); idle();
    dec_is_branch = 1'b1; dec_src1 = 5'd14;
    ex_dst = 5'd14; ex_wr_en = 1'b1; ex_rd_mem = 1'b1;
    #1;
    chk("R9 held no flush", fetch_flush, 0);
    chk("R9 stall raised", stall_front, 1);
    step();
    ex_wr_en = 1'b0; ex_rd_mem = 1'b0; ex_dst = 5'd0;
    #1;
    chk("R9 flush starts", fetch_flush, 1);
    for (int i = 1; i < NB; i++) begin
      step(); dec_is_branch = 1'b0;
      #1;
      chk("R9 flush run", fetch_flush, 1);
    end
    step();
    #1;
    chk("R9 flush ends", fetch_flush, 0);
  endtask

  initial begin
    t_reset();
    t_fwd_mem();
    t_fwd_wb();
    t_priority();
    t_zero_nowrite();
    t_load_use();
    t_wb_decode();
    t_branch();
    t_branch_stall();
    step(); idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule